// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of every beat of a memory burst. A controller presents a starting column, a length choice of four or eight beats, and a sequential or interleaved ordering, then pulses a start input. On the next cycle the sequencer begins to emit one column per clock. It raises a valid strobe for each beat and marks the final beat with a last flag. Every beat stays inside the aligned block that the starting column selects. The low bits wrap within that block and never carry into the fixed upper bits.

The sequencer takes the length and the ordering as inputs instead of holding them in a configuration register. These settings are captured together with the start column when a burst is accepted. They remain fixed until that burst ends. A start request that arrives while a burst is in flight is dropped. A busy output tells the requester that the sequencer is occupied.

Top module: `burst_col_seq`

## Requirements
- R1: After reset is released and before any start, `colValid`, `lastBeat` and `busy` are all low.
- R2: A start is accepted when `startPulse` is high at a rising edge while `busy` is low. From the next cycle, `colValid` is high and `colAddr` equals `startCol` for beat 0.
- R3: `colValid` stays high for exactly 4 consecutive cycles when `lenEight` was 0 at the accepted start, and for exactly 8 cycles when it was 1. The block presents one new beat per cycle and then returns low.
- R4: `lastBeat` is high only in the cycle that carries the final beat of a burst.
- R5: The fixed part of the address does not change during a burst. For four-beat bursts this is `colAddr[COL_W-1:2]`, and for eight-beat bursts it is `colAddr[COL_W-1:3]`. In both cases it equals the same bits of the start column.
- R6: With `interleaved`=1, the low bits of beat n are the low bits of the start column XOR n. These are bits [1:0] for four beats and bits [2:0] for eight beats.
- R7: With `interleaved`=0 and four beats, `colAddr[1:0]` of beat n equals (start[1:0] + n) mod 4.
- R8: With `interleaved`=0 and eight beats, `colAddr[1:0]` follows R7. `colAddr[2]` equals start[2] for beats 0 to 3 and its inverse for beats 4 to 7. For example, start 1 gives the order 1,2,3,0,5,6,7,4.
- R9: `busy` is high in every cycle of a burst. A start pulse during a burst is ignored, and the running sequence, its length and its last flag continue unchanged.
- R10: Changes on `startCol`, `lenEight` or `interleaved` after a start has been accepted have no effect on the burst in progress.
- R11: If `startPulse` is held high continuously, the next burst is accepted at the edge one idle cycle after the last beat. That leaves exactly one cycle with `colValid` low between the two bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Request to launch a burst |
| startCol | input | COL_W | Starting column address |
| lenEight | input | 1 | 1 selects eight beats, 0 selects four beats |
| interleaved | input | 1 | 1 selects XOR ordering, 0 selects sequential nibble ordering |
| colValid | output | 1 | High while a beat address is presented |
| colAddr | output | COL_W | Column address of the current beat |
| lastBeat | output | 1 | High with the final beat of a burst |
| busy | output | 1 | High while a burst is in progress |

## Verification
The hardest situation to reach is a start request that lands in the middle of a running burst while the address and mode inputs move as well. Only there do the drop rule and the capture-at-start rule show at the ports. The bench drives this case directly. It raises a second start and a different column, length and ordering at chosen beats of a running burst. It then checks that every remaining beat and the last flag still follow the original burst. A separate case holds the start input high across bursts to expose the one-cycle idle gap.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Beat index width covers the longest burst (8 beats)
  localparam int BEAT_W = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture a new burst
    logic step;  // advance to the next beat
  } seqStrobe_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       lenEight,
  output seqStrobe_t strobes,
  output logic       running,
  output logic       lastBeat
);

  localparam logic [BEAT_W-1:0] LAST_OF_FOUR  = BEAT_W'(3);
  localparam logic [BEAT_W-1:0] LAST_OF_EIGHT = BEAT_W'(7);

  logic [BEAT_W-1:0] remaining;

  always_comb begin
    lastBeat     = running && (remaining == '0);
    strobes.load = startPulse && !running;
    strobes.step = running && !lastBeat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      remaining <= '0;
    end else if (strobes.load) begin
      running   <= 1'b1;
      remaining <= lenEight ? LAST_OF_EIGHT : LAST_OF_FOUR;
    end else if (running) begin
      if (remaining == '0) running <= 1'b0;
      else                 remaining <= remaining - 1'b1;
    end
  end

  // R4
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |=> !running);

  // R3
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !lastBeat) |=> running);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && running && !lastBeat) |=> (remaining == $past(remaining) - 1'b1));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !running) |=> (running && !lastBeat));

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobes,
  input  logic [COL_W-1:0] startCol,
  input  logic             lenEight,
  input  logic             interleaved,
  output logic [COL_W-1:0] colAddr
);

  localparam int UPPER_W = COL_W - BEAT_W;

  logic [COL_W-1:0]  baseQ;
  logic              len8Q;
  logic              interQ;
  logic [BEAT_W-1:0] beatQ;
  logic [BEAT_W-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      len8Q  <= 1'b0;
      interQ <= 1'b0;
      beatQ  <= '0;
    end else if (strobes.load) begin
      baseQ  <= startCol;
      len8Q  <= lenEight;
      interQ <= interleaved;
      beatQ  <= '0;
    end else if (strobes.step) begin
      beatQ  <= beatQ + 1'b1;
    end
  end

  // Four-beat bursts never reach beat 4, so bit 2 is untouched for them
  always_comb begin
    if (interQ) begin
      lowBits = baseQ[BEAT_W-1:0] ^ beatQ;
    end else begin
      lowBits[1:0] = baseQ[1:0] + beatQ[1:0];
      lowBits[2]   = baseQ[2] ^ beatQ[2];
    end
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      assign colAddr = {baseQ[COL_W-1:BEAT_W], lowBits};
    end else begin : g_narrow
      assign colAddr = lowBits[COL_W-1:0];
    end
  endgenerate

  // R5
  len4_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !len8Q) |=> (colAddr[COL_W-1:2] == $past(colAddr[COL_W-1:2])));

  // R5
  len8_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && len8Q) |=> (colAddr[COL_W-1:3] == $past(colAddr[COL_W-1:3])));

  // R7
  beat_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (colAddr[0] != $past(colAddr[0])));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [COL_W-1:0] startCol,
  input  logic             lenEight,
  input  logic             interleaved,
  output logic             colValid,
  output logic [COL_W-1:0] colAddr,
  output logic             lastBeat,
  output logic             busy
);

  seqStrobe_t strobes;
  logic       running;

  burst_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .lenEight   (lenEight),
    .strobes    (strobes),
    .running    (running),
    .lastBeat   (lastBeat)
  );

  burst_seq_dp #(.COL_W(COL_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .startCol    (startCol),
    .lenEight    (lenEight),
    .interleaved (interleaved),
    .colAddr     (colAddr)
  );

  assign colValid = running;
  assign busy     = running;

  // R1
  reset_idle_chk: assert property (@(posedge clk) $fell(rstN) |-> (!colValid && !lastBeat));

endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic             lenEight = 1'b0;
  logic             interleaved = 1'b0;
  logic             colValid;
  logic [COL_W-1:0] colAddr;
  logic             lastBeat;
  logic             busy;

  int checks = 0;
  int errors = 0;

  burst_col_seq #(.COL_W(COL_W)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startCol(startCol),
    .lenEight(lenEight), .interleaved(interleaved), .colValid(colValid),
    .colAddr(colAddr), .lastBeat(lastBeat), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Vector: {lenEight, interleaved, startCol}
  localparam int NVEC = 10;
  localparam logic [COL_W+1:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 10'h001}, {1'b0, 1'b0, 10'h3FE}, {1'b0, 1'b1, 10'h123},
    {1'b0, 1'b1, 10'h2A1}, {1'b1, 1'b0, 10'h001}, {1'b1, 1'b0, 10'h156},
    {1'b1, 1'b0, 10'h3FF}, {1'b1, 1'b1, 10'h0B5}, {1'b1, 1'b1, 10'h2C2},
    {1'b1, 1'b0, 10'h008}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expAddr(input int col, input bit len8, input bit inter, input int n);
    int blk;
    int off;
    blk = len8 ? 8 : 4;
    if (inter)      off = (col ^ n) % blk;
    else if (!len8) off = (col + n) % 4;
    else            off = ((col + n) % 4) + 4 * (((col / 4) + (n / 4)) % 2);
    return (col - (col % blk)) + off;
  endfunction

  // Launch a burst and check every beat. At beat intrudeAt a second start
  // and new inputs are driven (R9, R10); -1 disables this.
  task automatic runBurst(input int col, input bit len8, input bit inter, input int intrudeAt);
    int bl;
    bl = len8 ? 8 : 4;
    @(negedge clk);
    startCol = COL_W'(col); lenEight = len8; interleaved = inter; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int n = 0; n < bl; n++) begin
      chk("R3 valid", int'(colValid), 1);
      chk("R9 busy", int'(busy), 1);
      chk(inter ? "R6 addr" : (len8 ? "R8 addr" : "R7 addr"),
          int'(colAddr), expAddr(col, len8, inter, n));
      chk("R5 upper", int'(colAddr) / (len8 ? 8 : 4), col / (len8 ? 8 : 4));
      chk("R4 last", int'(lastBeat), int'(n == bl - 1));
      if (n == 0) chk("R2 first", int'(colAddr), col);
      if (n == intrudeAt) begin
        startPulse = 1'b1;
        startCol = ~COL_W'(col);
        lenEight = ~len8;
        interleaved = ~inter;
      end
      @(negedge clk);
      startPulse = 1'b0;
    end
    chk("R3 end", int'(colValid), 0);
    chk("R9 idle", int'(busy), 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(colValid), 0);
    chk("R1 last", int'(lastBeat), 0);
    chk("R1 busy", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid", int'(colValid), 0);

    // Table-driven bursts
    for (int v = 0; v < NVEC; v++) begin
      runBurst(int'(VEC[v][COL_W-1:0]), VEC[v][COL_W+1], VEC[v][COL_W], -1);
    end

    // R9 R10: second start and changed inputs in mid burst
    runBurst(10'h0D3, 1'b1, 1'b0, 2);
    runBurst(10'h061, 1'b0, 1'b1, 1);
    runBurst(10'h14E, 1'b1, 1'b1, 7);
    runBurst(10'h2B6, 1'b0, 1'b0, 3);

    // R11: start held high spans two bursts with one idle gap
    @(negedge clk);
    startCol = 10'h005; lenEight = 1'b0; interleaved = 1'b0; startPulse = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 4; n++) begin
      chk("R11 first burst", int'(colAddr), expAddr(5, 1'b0, 1'b0, n));
      @(negedge clk);
    end
    chk("R11 gap", int'(colValid), 0);
    startCol = 10'h00A;
    @(negedge clk);
    startPulse = 1'b0;
    chk("R11 relaunch", int'(colValid), 1);
    chk("R11 relaunch addr", int'(colAddr), 10'h00A);
    repeat (4) @(negedge clk);
    chk("R11 done", int'(colValid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule